// File: doc/BRIEF.md
# Histogram Bin Accumulator

This block builds a histogram of events in on-chip memory. Each incoming event names a bin. The block fetches that bin's count, adds one, and stores the result back to the same bin. Fetch and store form a pipeline that takes one event on every clock. Every stage carries a valid flag and the bin address, and the stages shift on every clock whether or not an event is present. The store therefore lands on the bin the fetch came from, and empty slots never write. When an event hits a bin whose earlier update has not yet reached memory, the newest pending count replaces the stale memory word. Each event then adds exactly one.

A sampling period opens with a `period_start` pulse and closes with a `period_end` pulse. After the close, the block lets the pipeline empty. It then streams every bin to the host in ascending order over a valid/ready port and writes zero into each bin as the host takes it, so the next period can start right after the last beat. Events that arrive outside a period are discarded and counted. After reset the block sweeps the whole memory to zero before it accepts a period. The default configuration is small. Setting `ADDR_W` to 16 gives 65536 bins of 64 bits.

Top module: `hist_accum`

## Requirements
- R1: While reset is asserted, `ready`, `done` and `rd_valid` are low. After reset is released, the block writes zero to all 2^ADDR_W bins, one per cycle, and then raises `ready`. This takes no more than 2^ADDR_W + 4 cycles.
- R2: Inside a period, each cycle with `ev_valid` high adds exactly one to bin `ev_bin`. One event is accepted per clock, with no gaps needed.
- R3: Events on the same bin still add one each when they follow each other closely: back to back, or separated by fewer cycles than the memory read latency.
- R4: An event presented in the same cycle as `period_end` is counted.
- R5: An event with `ev_valid` high outside a period leaves every bin unchanged and raises `drop_count` by one. This covers the drain, the readout, and the waits before and after a period. `period_start` clears `drop_count` to zero.
- R6: After `period_end`, the pipeline empties. The port then offers bins 0 to 2^ADDR_W-1 in ascending order on `rd_bin`/`rd_count`, with `rd_last` high only on the final bin.
- R7: While `rd_valid` is high and `rd_ready` is low, `rd_valid`, `rd_bin` and `rd_count` hold their values.
- R8: A bin accepted by the host (`rd_valid` and `rd_ready` both high) is cleared to zero. The next period counts from zero.
- R9: `done` rises in the cycle after the final handshake and stays high until the next `period_start`. `ready` is high at the same time, and `done` is low during a period.
- R10: Counts wrap modulo 2^CNT_W; they do not saturate.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| period_start | input | 1 | One-cycle pulse that opens a sampling period (taken only while `ready`) |
| period_end | input | 1 | One-cycle pulse that closes the running period |
| ev_valid | input | 1 | Event present this cycle |
| ev_bin | input | ADDR_W | Bin index of the event |
| rd_valid | output | 1 | Readout beat offered |
| rd_ready | input | 1 | Host accepts the offered beat |
| rd_bin | output | ADDR_W | Bin index of the offered beat |
| rd_count | output | CNT_W | Count of the offered bin |
| rd_last | output | 1 | Offered beat is the final bin |
| ready | output | 1 | A new period may be started |
| done | output | 1 | Readout of the last period is complete |
| drop_count | output | DROP_W | Events discarded since the last period start |

## Verification
A fault inside the block reaches the ports only when the bins are read out. A write-back address that is out of step with the data, a forwarding path that picks a stale or wrong entry, or a valid flag that does not follow its stage all show up as a wrong `rd_count` on some bin, one readout after the damage. The dense stimulus (every ordered pair of bins back to back, same-bin bursts, and spacings just inside and just outside the read latency) makes sure that each such fault disturbs at least one bin the bench predicts exactly. Faults in the sequencing show up sooner. A missed clear appears as a nonzero count in the next period, a wrong bin order appears on the first stalled beat, and a wrong drop count appears as soon as the readout ends.

// File: rtl/hist_pkg.sv
package hist_pkg;

  typedef enum logic [2:0] {
    ST_CLEAR,
    ST_IDLE,
    ST_RUN,
    ST_DRAIN,
    ST_FETCH,
    ST_OFFER,
    ST_DONE
  } hist_state_e;

endpackage

// File: rtl/hist_ram.sv
// Count storage: one read port and one write port.
// Read data appears RD_LAT cycles after the address is presented.
// A read that collides with a write in the same cycle returns the old word.
module hist_ram #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic [ADDR_W-1:0] rd_addr,
  output logic [CNT_W-1:0]  rd_data,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [CNT_W-1:0]  wr_data
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [CNT_W-1:0] mem [DEPTH];
  logic [CNT_W-1:0] q   [1:RD_LAT];

  always_ff @(posedge clk) begin
    if (wr_en) mem[wr_addr] <= wr_data;
    q[1] <= mem[rd_addr];
  end

  // Extra output stages when the read latency is above one cycle.
  for (genvar k = 2; k <= RD_LAT; k++) begin : g_qstage
    always_ff @(posedge clk) q[k] <= q[k-1];
  end

  assign rd_data = q[RD_LAT];

endmodule

// File: rtl/hist_pipe.sv
// Read-modify-write pipeline. Valid and address travel with the memory
// read so the write-back stage sees the event that produced the data.
// A short history of recent writes covers updates not yet visible to a read.
module hist_pipe #(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64,
  parameter int RD_LAT = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  input  logic [ADDR_W-1:0] in_addr,
  input  logic [CNT_W-1:0]  mem_q,
  input  logic              seen_we,
  input  logic [ADDR_W-1:0] seen_addr,
  input  logic [CNT_W-1:0]  seen_data,
  output logic              upd_we,
  output logic [ADDR_W-1:0] upd_addr,
  output logic [CNT_W-1:0]  upd_data,
  output logic              busy
);
  logic [RD_LAT:1]   sv,   sv_d;
  logic [ADDR_W-1:0] sa   [1:RD_LAT];
  logic [ADDR_W-1:0] sa_d [1:RD_LAT];
  logic [RD_LAT:1]   hv,   hv_d;
  logic [ADDR_W-1:0] ha   [1:RD_LAT];
  logic [ADDR_W-1:0] ha_d [1:RD_LAT];
  logic [CNT_W-1:0]  hd   [1:RD_LAT];
  logic [CNT_W-1:0]  hd_d [1:RD_LAT];

  // Next-state of every stage: each advances on every clock.
  for (genvar k = 1; k <= RD_LAT; k++) begin : g_next
    if (k == 1) begin : g_head
      assign sv_d[k] = in_valid;
      assign sa_d[k] = in_addr;
      assign hv_d[k] = seen_we;
      assign ha_d[k] = seen_addr;
      assign hd_d[k] = seen_data;
    end else begin : g_body
      assign sv_d[k] = sv[k-1];
      assign sa_d[k] = sa[k-1];
      assign hv_d[k] = hv[k-1];
      assign ha_d[k] = ha[k-1];
      assign hd_d[k] = hd[k-1];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sv <= '0;
      hv <= '0;
    end else begin
      sv <= sv_d;
      hv <= hv_d;
    end
  end

  always_ff @(posedge clk) begin
    for (int k = 1; k <= RD_LAT; k++) begin
      sa[k] <= sa_d[k];
      ha[k] <= ha_d[k];
      hd[k] <= hd_d[k];
    end
  end

  // Newest matching write wins: scan from oldest to newest.
  logic             hit;
  logic [CNT_W-1:0] fwd;
  always_comb begin
    hit = 1'b0;
    fwd = '0;
    for (int k = RD_LAT; k >= 1; k--) begin
      if (hv[k] && (ha[k] == sa[RD_LAT])) begin
        hit = 1'b1;
        fwd = hd[k];
      end
    end
  end

  assign upd_we   = sv[RD_LAT];
  assign upd_addr = sa[RD_LAT];
  assign upd_data = (hit ? fwd : mem_q) + CNT_W'(1);
  assign busy     = |sv;

endmodule

// File: rtl/hist_ctrl.sv
// Period sequencing: clear sweep after reset, event gating, drain,
// ascending readout with clear-on-read, drop counting.
module hist_ctrl
  import hist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64,
  parameter int RD_LAT = 2,
  parameter int DROP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic              period_end,
  input  logic              ev_valid,
  input  logic              pipe_busy,
  input  logic [CNT_W-1:0]  mem_q,
  output logic              accept,
  output logic [ADDR_W-1:0] ctl_addr,
  output logic              clr_we,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_last,
  output logic              ready,
  output logic              done,
  output logic [DROP_W-1:0] drop_count
);
  localparam int                WAIT_W   = $clog2(RD_LAT + 1);
  localparam logic [ADDR_W-1:0] LAST_BIN = '1;
  localparam logic [WAIT_W-1:0] WAIT_END = WAIT_W'(RD_LAT);

  hist_state_e       st, st_n;
  logic [ADDR_W-1:0] ctr, ctr_n;
  logic [WAIT_W-1:0] wcnt, wcnt_n;
  logic [DROP_W-1:0] drop_q, drop_n;
  logic [CNT_W-1:0]  cnt_q;
  logic              cnt_en;

  always_comb begin
    st_n   = st;
    ctr_n  = ctr;
    wcnt_n = wcnt;
    drop_n = drop_q;
    cnt_en = 1'b0;
    clr_we = 1'b0;
    if (ev_valid && (st != ST_RUN)) drop_n = drop_q + DROP_W'(1);
    case (st)
      ST_CLEAR: begin
        clr_we = 1'b1;
        ctr_n  = ctr + ADDR_W'(1);
        if (ctr == LAST_BIN) st_n = ST_IDLE;
      end
      ST_IDLE, ST_DONE: begin
        if (period_start) begin
          st_n   = ST_RUN;
          drop_n = '0;
        end
      end
      ST_RUN: begin
        if (period_end) st_n = ST_DRAIN;
      end
      ST_DRAIN: begin
        if (!pipe_busy) begin
          st_n   = ST_FETCH;
          ctr_n  = '0;
          wcnt_n = '0;
        end
      end
      ST_FETCH: begin
        if (wcnt == WAIT_END) begin
          cnt_en = 1'b1;
          st_n   = ST_OFFER;
        end else begin
          wcnt_n = wcnt + WAIT_W'(1);
        end
      end
      ST_OFFER: begin
        if (rd_ready) begin
          clr_we = 1'b1;
          ctr_n  = ctr + ADDR_W'(1);
          wcnt_n = '0;
          st_n   = (ctr == LAST_BIN) ? ST_DONE : ST_FETCH;
        end
      end
      default: st_n = ST_CLEAR;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st     <= ST_CLEAR;
      ctr    <= '0;
      wcnt   <= '0;
      drop_q <= '0;
    end else begin
      st     <= st_n;
      ctr    <= ctr_n;
      wcnt   <= wcnt_n;
      drop_q <= drop_n;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      cnt_q <= '0;
    else if (cnt_en) cnt_q <= mem_q;
  end

  assign accept     = ev_valid && (st == ST_RUN);
  assign ctl_addr   = ctr;
  assign rd_valid   = (st == ST_OFFER);
  assign rd_bin     = ctr;
  assign rd_count   = cnt_q;
  assign rd_last    = (st == ST_OFFER) && (ctr == LAST_BIN);
  assign ready      = (st == ST_IDLE) || (st == ST_DONE);
  assign done       = (st == ST_DONE);
  assign drop_count = drop_q;

  // R7: an offered beat is held until the host takes it.
  assert_beat_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (rd_valid && !rd_ready) |=> (rd_valid && $stable(rd_bin) && $stable(rd_count)));

  // R6: readout never runs while updates are still in flight.
  assert_drained_before_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
    rd_valid |-> !pipe_busy);

  // R9: done rises only right after the final handshake.
  assert_done_after_last_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done) |-> $past(rd_valid && rd_ready && rd_last));

endmodule

// File: rtl/hist_accum.sv
module hist_accum
  import hist_pkg::*;
#(
  parameter int ADDR_W = 8,
  parameter int CNT_W  = 64,
  parameter int RD_LAT = 2,
  parameter int DROP_W = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              period_start,
  input  logic              period_end,
  input  logic              ev_valid,
  input  logic [ADDR_W-1:0] ev_bin,
  output logic              rd_valid,
  input  logic              rd_ready,
  output logic [ADDR_W-1:0] rd_bin,
  output logic [CNT_W-1:0]  rd_count,
  output logic              rd_last,
  output logic              ready,
  output logic              done,
  output logic [DROP_W-1:0] drop_count
);
  // Reset: asserted asynchronously, released on a clock edge.
  logic [1:0] rst_sync;
  logic       rst_s;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync <= 2'b00;
    else        rst_sync <= {rst_sync[0], 1'b1};
  end
  assign rst_s = rst_sync[1];

  logic              accept, clr_we, upd_we, busy;
  logic [ADDR_W-1:0] ctl_addr, upd_addr;
  logic [CNT_W-1:0]  mem_q, upd_data;
  logic              ram_we;
  logic [ADDR_W-1:0] ram_ra, ram_wa;
  logic [CNT_W-1:0]  ram_wd;

  assign ram_ra = accept ? ev_bin : ctl_addr;
  assign ram_we = upd_we | clr_we;
  assign ram_wa = upd_we ? upd_addr : ctl_addr;
  assign ram_wd = upd_we ? upd_data : '0;

  hist_ram #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT)) u_ram (
    .clk     (clk),
    .rd_addr (ram_ra),
    .rd_data (mem_q),
    .wr_en   (ram_we),
    .wr_addr (ram_wa),
    .wr_data (ram_wd)
  );

  hist_pipe #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT)) u_pipe (
    .clk       (clk),
    .rst_n     (rst_s),
    .in_valid  (accept),
    .in_addr   (ev_bin),
    .mem_q     (mem_q),
    .seen_we   (ram_we),
    .seen_addr (ram_wa),
    .seen_data (ram_wd),
    .upd_we    (upd_we),
    .upd_addr  (upd_addr),
    .upd_data  (upd_data),
    .busy      (busy)
  );

  hist_ctrl #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .RD_LAT(RD_LAT), .DROP_W(DROP_W)) u_ctrl (
    .clk          (clk),
    .rst_n        (rst_s),
    .period_start (period_start),
    .period_end   (period_end),
    .ev_valid     (ev_valid),
    .pipe_busy    (busy),
    .mem_q        (mem_q),
    .accept       (accept),
    .ctl_addr     (ctl_addr),
    .clr_we       (clr_we),
    .rd_valid     (rd_valid),
    .rd_ready     (rd_ready),
    .rd_bin       (rd_bin),
    .rd_count     (rd_count),
    .rd_last      (rd_last),
    .ready        (ready),
    .done         (done),
    .drop_count   (drop_count)
  );

  // R8: a clear-on-read write never competes with an event update.
  assert_single_writer_R8: assert property (@(posedge clk) disable iff (!rst_s)
    !(upd_we && clr_we));

  // R5: the drop counter only steps by one or returns to zero.
  assert_drop_step_R5: assert property (@(posedge clk) disable iff (!rst_s)
    (drop_count != $past(drop_count)) |->
      ((drop_count == $past(drop_count) + DROP_W'(1)) || (drop_count == '0)));

endmodule

// File: tb/hist_accum_test.sv
module hist_accum_test;
  localparam int AW  = 3;
  localparam int CW  = 4;
  localparam int LAT = 2;
  localparam int DW  = 8;
  localparam int NB  = 1 << AW;
  localparam int MOD = 1 << CW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          period_start, period_end, ev_valid, rd_ready;
  logic [AW-1:0] ev_bin;
  logic          rd_valid, rd_last, ready, done;
  logic [AW-1:0] rd_bin;
  logic [CW-1:0] rd_count;
  logic [DW-1:0] drop_count;

  always #5 clk = ~clk;

  hist_accum #(.ADDR_W(AW), .CNT_W(CW), .RD_LAT(LAT), .DROP_W(DW)) uut (
    .clk(clk), .rst_n(rst_n), .period_start(period_start), .period_end(period_end),
    .ev_valid(ev_valid), .ev_bin(ev_bin), .rd_valid(rd_valid), .rd_ready(rd_ready),
    .rd_bin(rd_bin), .rd_count(rd_count), .rd_last(rd_last), .ready(ready),
    .done(done), .drop_count(drop_count)
  );

  int  n_chk  = 0;
  int  n_fail = 0;
  int  exp_cnt [NB];
  int  exp_drop = 0;
  bit  finished = 0;

  task automatic check(input bit ok, input string req, input int act, input int expv);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %0d expected %0d", req, act, expv);
    end
  endtask

  task automatic report();
    if (!finished) begin
      finished = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  endtask

  // One cycle of event input; the model counts it if counted is set.
  task automatic ev(input int b, input bit counted);
    ev_valid = 1'b1;
    ev_bin   = AW'(b);
    if (counted) exp_cnt[b] = (exp_cnt[b] + 1) % MOD;
    else         exp_drop++;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    ev_valid = 1'b0;
    repeat (n) @(negedge clk);
  endtask

  task automatic start_period();
    period_start = 1'b1;
    @(negedge clk);
    period_start = 1'b0;
    exp_drop = 0;
    check(drop_count == 0, "R5 drop clear", int'(drop_count), 0);
    check(done == 0 && ready == 0, "R9 done low in period", int'(done), 0);
  endtask

  // Full readout; stall_mask selects beats that see backpressure,
  // drop_beat injects an event while that beat is offered.
  task automatic readout(input int stall_mask, input int drop_beat);
    for (int i = 0; i < NB; i++) begin
      int guard = 0;
      while (!rd_valid && guard < 40) begin
        @(negedge clk);
        guard++;
      end
      check(rd_valid == 1, "R6 beat offered", int'(rd_valid), 1);
      check(int'(rd_bin) == i, "R6 ascending bin", int'(rd_bin), i);
      check(int'(rd_count) == exp_cnt[i], "R2 R3 R10 bin count", int'(rd_count), exp_cnt[i]);
      check(rd_last == (i == NB - 1), "R6 last flag", int'(rd_last), int'(i == NB - 1));
      if (stall_mask[i]) begin
        for (int s = 0; s < 3; s++) begin
          @(negedge clk);
          check(rd_valid == 1 && int'(rd_bin) == i && int'(rd_count) == exp_cnt[i],
                "R7 hold under stall", int'(rd_count), exp_cnt[i]);
        end
      end
      if (i == drop_beat) begin
        ev_valid = 1'b1;
        ev_bin   = AW'(i);
        exp_drop++;
      end
      rd_ready = 1'b1;
      @(negedge clk);
      rd_ready = 1'b0;
      ev_valid = 1'b0;
      exp_cnt[i] = 0;
    end
    check(done == 1 && ready == 1, "R9 done after last", int'(done), 1);
    check(rd_valid == 0, "R9 no beat after last", int'(rd_valid), 0);
    check(int'(drop_count) == exp_drop, "R5 drop count", int'(drop_count), exp_drop);
  endtask

  initial begin
    #(200000 * 10);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung expected finish");
      report();
    end
  end

  initial begin
    int waited;
    for (int b = 0; b < NB; b++) exp_cnt[b] = 0;
    rst_n = 1'b0; period_start = 0; period_end = 0; ev_valid = 0; ev_bin = '0; rd_ready = 0;
    repeat (3) @(negedge clk);
    check(ready == 0 && done == 0 && rd_valid == 0, "R1 reset state",
          int'({ready, done, rd_valid}), 0);
    rst_n = 1'b1;
    waited = 0;
    while (!ready && waited < 100) begin
      @(negedge clk);
      waited++;
    end
    check(ready == 1 && waited <= NB + 4, "R1 clear sweep length", waited, NB + 4);

    // R5: events before any period are dropped and counted.
    ev(1, 0); ev(4, 0); ev(1, 0); idle(1);
    check(int'(drop_count) == exp_drop, "R5 drops while idle", int'(drop_count), exp_drop);

    // Period 1: empty period, bins must read zero after the reset sweep (R1).
    start_period();
    period_end = 1'b1; @(negedge clk); period_end = 1'b0;
    readout(0, -1);

    // Period 2: dense patterns.
    start_period();
    for (int b = 0; b < NB; b++)
      for (int n = 0; n <= b; n++) ev(b, 1);           // R3 same-bin bursts
    for (int k = 0; k < 12; k++) ev((k % 2) ? 2 : 6, 1); // R3 alternating pair
    for (int gap = 0; gap <= LAT + 1; gap++) begin       // R3 spacing sweep
      ev(5, 1); idle(gap); ev(5, 1);
    end
    for (int b1 = 0; b1 < NB; b1++)                      // R2 every ordered pair
      for (int b2 = 0; b2 < NB; b2++) begin
        ev(b1, 1); ev(b2, 1);
      end
    for (int n = 0; n < 20; n++) ev(7, 1);               // R10 wrap
    period_end = 1'b1;
    ev(3, 1);                                            // R4 same-cycle event
    period_end = 1'b0;
    ev(0, 0); ev(0, 0);                                  // R5 drops during drain
    idle(0);
    readout(32'b0100_1010, 3);

    // Period 3: counts start from zero after clear-on-read (R8).
    start_period();
    ev(2, 1); ev(2, 1); ev(6, 1);
    period_end = 1'b1; ev_valid = 1'b0; @(negedge clk); period_end = 1'b0;
    readout(32'b1000_0001, -1);

    report();
  end

endmodule